// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block produces the external memory strobes for a small controller whose low address byte and data byte share one port (port 0), while the high address byte has its own port (port 2). It runs on the oscillator clock and divides time into machine cycles of twelve clocks. Each machine cycle is split into two six-clock halves. When no data access is asked for, each half is one code fetch: an address latch pulse, a short address hold, then a program-store strobe while the port floats and the memory returns a byte.

A data read or write takes a whole machine cycle. It has a single address latch pulse, no program-store strobes, and one long read or write strobe. A write drives its byte on port 0 around that strobe. Requests are taken at fixed phase boundaries, which the block signals with `half_last` and `mc_last`. Bytes returned by the memory are captured on the last clock of each strobe window and presented on `rdata` with a one-clock valid pulse.

Top module: `xbus_sequencer`

## Requirements
- R1: While `rst` is high, `ale` is 1, `psen_n`, `rd_n` and `wr_n` are 1, `p0_oe` is 0, `p2_out` is all ones, and `rdata_valid` is 0. The first clock after `rst` falls is phase 0 of a fetch machine cycle at address 0.
- R2: A machine cycle is 12 clocks, numbered 0 to 11, and each half is 6 clocks, numbered 0 to 5. In a fetch cycle, `ale` is high on half phases 0 and 1 and low on half phases 2 to 5, so it pulses every 6 clocks for 2 clocks.
- R3: In a fetch half, `p0_oe` is 1 and `p0_out` carries the address bits [7:0] on half phases 0 to 2, which is one clock past the fall of `ale`. `p0_oe` is 0 on half phases 3 to 5.
- R4: In a fetch half, `psen_n` is low on half phases 3 to 5, starting one clock after `ale` falls and lasting 3 clocks.
- R5: `p0_in` is sampled on the clock edge that ends the last clock of each strobe window (fetch half phase 5, read phase 10). On the next clock, `rdata` holds that byte and `rdata_valid` is 1. On all other clocks `rdata_valid` is 0.
- R6: In a data read or write machine cycle, `ale` is high only on phases 0 and 1, so the pulse at phase 6 is dropped. `psen_n` stays high for all 12 phases.
- R7: In a read cycle, `rd_n` is low on phases 5 to 10, starting 3 clocks after `ale` falls and lasting 6 clocks. `p0_oe` is 1 with the address bits [7:0] on phases 0 to 2 and 0 on phases 3 to 11.
- R8: In a write cycle, `wr_n` is low on phases 5 to 10. `p0_oe` stays 1 for the whole cycle: address bits [7:0] on phases 0 to 2, then the write byte on phases 3 to 11, which is 2 clocks before `wr_n` falls and 1 clock after it rises.
- R9: `p2_out` carries address bits [15:8] and changes only at phase 0 of a half. It is constant across a whole fetch half and across a whole data machine cycle.
- R10: `half_last` is high on phases 5 and 11, and `mc_last` is high on phase 11. `code_addr` is taken for the next fetch half on an edge with `half_last` high. `data_rd`, `data_wr`, `data_addr` and `data_wdata` are taken only on an edge with `mc_last` high. When both `data_rd` and `data_wr` are high, the read is taken.
- R11: At most one of `psen_n`, `rd_n` and `wr_n` is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| code_addr | input | ADDR_W (16) | Fetch address for the next half |
| data_rd | input | 1 | Request a data read in the next machine cycle |
| data_wr | input | 1 | Request a data write in the next machine cycle |
| data_addr | input | ADDR_W (16) | Data access address |
| data_wdata | input | DATA_W (8) | Byte to write |
| p0_in | input | DATA_W (8) | Port 0 pad input |
| half_last | output | 1 | Last clock of a half cycle |
| mc_last | output | 1 | Last clock of a machine cycle |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | DATA_W (8) | Port 0 drive value |
| p0_oe | output | 1 | Port 0 output enable |
| p2_out | output | ADDR_W-DATA_W (8) | High address byte |
| rdata | output | DATA_W (8) | Captured byte |
| rdata_valid | output | 1 | One-clock pulse for a new `rdata` |

## Verification
The strobe, port and phase outputs are combinational from the phase counter and the latched request, so they are due in the same clock as their phase. The bench compares them on every falling edge against a phase model it keeps itself. A request given during phase 5 or 11 takes effect from the next clock, at phase 6 or 0. A byte driven on `p0_in` during the sampling clock is due on `rdata` one clock later, and the bench expects `rdata_valid` and the byte exactly there and nowhere else. Twenty machine cycles cycle through fetch, read, write and a conflicting read-plus-write request, each with different addresses and data.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_e;

    // timing in oscillator clocks
    localparam int MC_LEN          = 12;
    localparam int HALF_LEN        = MC_LEN / 2;
    localparam int ALE_LEN         = 2;
    localparam int ADDR_HOLD       = 1;
    localparam int ADDR_PHASES     = ALE_LEN + ADDR_HOLD;
    localparam int CODE_STB_START  = ADDR_PHASES;
    localparam int CODE_STB_LEN    = HALF_LEN - CODE_STB_START;
    localparam int DATA_STB_GAP    = 3;
    localparam int DATA_STB_START  = ALE_LEN + DATA_STB_GAP;
    localparam int DATA_STB_LEN    = 6;
    localparam int PH_W            = $clog2(MC_LEN);

    localparam logic [PH_W-1:0] PH_LAST      = PH_W'(MC_LEN - 1);
    localparam logic [PH_W-1:0] PH_HALF      = PH_W'(HALF_LEN);
    localparam logic [PH_W-1:0] PH_HALF_LAST = PH_W'(HALF_LEN - 1);
    localparam logic [PH_W-1:0] PH_RD_SAMPLE = PH_W'(DATA_STB_START + DATA_STB_LEN - 1);

    typedef struct packed {
        logic ale;
        logic psen_n;
        logic rd_n;
        logic wr_n;
        logic p0_oe;
    } strobe_t;

    function automatic logic in_win(logic [PH_W-1:0] p, int start, int len);
        int pi;
        pi = int'(p);
        return (pi >= start) && (pi < start + len);
    endfunction

endpackage

// File: rtl/xbus_phase.sv
module xbus_phase
    import xbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] ph,
    output logic [PH_W-1:0] hph,
    output logic            half_last,
    output logic            mc_last
);
    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst)                 ph_q <= '0;
        else if (ph_q == PH_LAST) ph_q <= '0;
        else                     ph_q <= ph_q + 1'b1;
    end

    always_comb begin
        ph        = ph_q;
        hph       = (ph_q >= PH_HALF) ? (ph_q - PH_HALF) : ph_q;
        half_last = (hph == PH_HALF_LAST);
        mc_last   = (ph_q == PH_LAST);
    end
endmodule

// File: rtl/xbus_req_latch.sv
module xbus_req_latch
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_last,
    input  logic              mc_last,
    input  logic [ADDR_W-1:0] code_addr,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [DATA_W-1:0] data_wdata,
    output cyc_kind_e         kind,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            kind  <= CYC_FETCH;
            addr  <= '0;
            wdata <= '0;
        end else if (mc_last) begin
            // read wins over write when both are asked for
            if (data_rd) begin
                kind <= CYC_READ;
                addr <= data_addr;
            end else if (data_wr) begin
                kind  <= CYC_WRITE;
                addr  <= data_addr;
                wdata <= data_wdata;
            end else begin
                kind <= CYC_FETCH;
                addr <= code_addr;
            end
        end else if (half_last && kind == CYC_FETCH) begin
            addr <= code_addr;
        end
    end
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     rst,
    input  logic [PH_W-1:0]          ph,
    input  logic [PH_W-1:0]          hph,
    input  cyc_kind_e                kind,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output strobe_t                  stb,
    output logic [DATA_W-1:0]        p0_out,
    output logic [ADDR_W-DATA_W-1:0] p2_out
);
    logic            is_fetch;
    logic [PH_W-1:0] win_ph;
    logic            addr_phase;
    logic            data_stb;

    always_comb begin
        is_fetch   = (kind == CYC_FETCH);
        // fetch timing repeats per half, data timing spans the whole cycle
        win_ph     = is_fetch ? hph : ph;
        addr_phase = in_win(win_ph, 0, ADDR_PHASES);
        data_stb   = !is_fetch && in_win(ph, DATA_STB_START, DATA_STB_LEN);

        stb.ale    = in_win(win_ph, 0, ALE_LEN);
        stb.psen_n = !(is_fetch && in_win(hph, CODE_STB_START, CODE_STB_LEN));
        stb.rd_n   = !(data_stb && kind == CYC_READ);
        stb.wr_n   = !(data_stb && kind == CYC_WRITE);
        stb.p0_oe  = addr_phase || (kind == CYC_WRITE);
        p0_out     = addr_phase ? addr[DATA_W-1:0] : wdata;
        p2_out     = addr[ADDR_W-1:DATA_W];

        if (rst) begin
            stb.ale    = 1'b1;
            stb.psen_n = 1'b1;
            stb.rd_n   = 1'b1;
            stb.wr_n   = 1'b1;
            stb.p0_oe  = 1'b0;
            p0_out     = '0;
            p2_out     = '1;
        end
    end
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic [DATA_W-1:0] p0_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= sample;
            if (sample) rdata <= p0_in;
        end
    end
endmodule

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        code_addr,
    input  logic                     data_rd,
    input  logic                     data_wr,
    input  logic [ADDR_W-1:0]        data_addr,
    input  logic [DATA_W-1:0]        data_wdata,
    input  logic [DATA_W-1:0]        p0_in,
    output logic                     half_last,
    output logic                     mc_last,
    output logic                     ale,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [DATA_W-1:0]        p0_out,
    output logic                     p0_oe,
    output logic [ADDR_W-DATA_W-1:0] p2_out,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rdata_valid
);
    logic [PH_W-1:0]   ph;
    logic [PH_W-1:0]   hph;
    cyc_kind_e         kind;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    strobe_t           stb;
    logic              sample;

    xbus_phase u_phase (
        .clk(clk), .rst(rst), .ph(ph), .hph(hph),
        .half_last(half_last), .mc_last(mc_last)
    );

    xbus_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk(clk), .rst(rst), .half_last(half_last), .mc_last(mc_last),
        .code_addr(code_addr), .data_rd(data_rd), .data_wr(data_wr),
        .data_addr(data_addr), .data_wdata(data_wdata),
        .kind(kind), .addr(cur_addr), .wdata(cur_wdata)
    );

    xbus_strobe_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stb (
        .rst(rst), .ph(ph), .hph(hph), .kind(kind), .addr(cur_addr),
        .wdata(cur_wdata), .stb(stb), .p0_out(p0_out), .p2_out(p2_out)
    );

    // last clock of a code strobe or of a read strobe
    assign sample = !rst && ((kind == CYC_FETCH && half_last) ||
                             (kind == CYC_READ && ph == PH_RD_SAMPLE));

    xbus_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst(rst), .sample(sample), .p0_in(p0_in),
        .rdata(rdata), .rdata_valid(rdata_valid)
    );

    assign ale    = stb.ale;
    assign psen_n = stb.psen_n;
    assign rd_n   = stb.rd_n;
    assign wr_n   = stb.wr_n;
    assign p0_oe  = stb.p0_oe;
endmodule

// File: rtl/xbus_sequencer_chk.sv
module xbus_sequencer_chk #(
    parameter int HI_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            ale,
    input logic            psen_n,
    input logic            rd_n,
    input logic            wr_n,
    input logic            p0_oe,
    input logic            half_last,
    input logic [HI_W-1:0] p2_out
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |-> (ale && psen_n && rd_n && wr_n && !p0_oe));

    a_r2_ale_width: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |=> ale ##1 !ale);

    a_r4_psen_width: assert property (@(posedge clk) disable iff (rst)
        $fell(psen_n) |=> !psen_n ##1 !psen_n ##1 psen_n);

    a_r3_float_in_strobe: assert property (@(posedge clk) disable iff (rst)
        (!psen_n || !rd_n) |-> !p0_oe);

    a_r7_rd_after_ale: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n) |-> ($past(ale, 4) && !$past(ale, 3) && !ale));

    a_r8_wr_data_held: assert property (@(posedge clk) disable iff (rst)
        (!wr_n || $rose(wr_n)) |-> p0_oe);

    a_r9_p2_stable: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(half_last)) |-> $stable(p2_out));

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1);
endmodule

bind xbus_sequencer xbus_sequencer_chk #(.HI_W(ADDR_W - DATA_W)) u_chk (
    .clk(clk), .rst(rst), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .p0_oe(p0_oe), .half_last(half_last), .p2_out(p2_out)
);

// File: tb/xbus_sequencer_tb.sv
module xbus_sequencer_tb;
    localparam int AW  = 16;
    localparam int DW  = 8;
    localparam int NMC = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] code_addr, data_addr;
    logic          data_rd, data_wr;
    logic [DW-1:0] data_wdata, p0_in;
    logic          half_last, mc_last, ale, psen_n, rd_n, wr_n, p0_oe, rdata_valid;
    logic [DW-1:0] p0_out, rdata;
    logic [AW-DW-1:0] p2_out;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    always #5 clk = ~clk;

    xbus_sequencer #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .code_addr(code_addr), .data_rd(data_rd),
        .data_wr(data_wr), .data_addr(data_addr), .data_wdata(data_wdata),
        .p0_in(p0_in), .half_last(half_last), .mc_last(mc_last), .ale(ale),
        .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out),
        .p0_oe(p0_oe), .p2_out(p2_out), .rdata(rdata), .rdata_valid(rdata_valid)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] fa(int m, int h);
        return AW'(16'hC000 ^ (m * 16'h0135) ^ (h * 16'h2A01));
    endfunction
    function automatic logic [AW-1:0] da(int m);
        return AW'(m * 16'h0F11 + 16'h8003);
    endfunction
    function automatic logic [DW-1:0] wdv(int m);
        return DW'(m * 29 + 7);
    endfunction
    // 0 fetch, 1 read, 2 write, 3 read and write together
    function automatic int sched(int m);
        case (m % 5)
            1:       return 1;
            3:       return 2;
            4:       return 3;
            default: return 0;
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int            kind;
        logic [AW-1:0] a, na;
        logic [DW-1:0] wd, nwd, pin, pend_data;
        int            nk;
        bit            pend_valid, sample_now;

        rst = 1'b1; code_addr = '0; data_addr = '0; data_rd = 1'b0;
        data_wr = 1'b0; data_wdata = '0; p0_in = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 ale", 32'(ale), 32'd1);
        chk("R1 psen_n", 32'(psen_n), 32'd1);
        chk("R1 rd_n", 32'(rd_n), 32'd1);
        chk("R1 wr_n", 32'(wr_n), 32'd1);
        chk("R1 p0_oe", 32'(p0_oe), 32'd0);
        chk("R1 p2_out", 32'(p2_out), 32'hFF);
        chk("R1 rdata_valid", 32'(rdata_valid), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        kind = 0; a = '0; na = '0; wd = '0; nwd = '0; nk = 0;
        pend_valid = 1'b0; pend_data = '0;

        for (int m = 0; m < NMC; m++) begin
            for (int ph = 0; ph < 12; ph++) begin
                int hp;
                bit e_ale, e_psen, e_rd, e_wr, e_oe;
                logic [DW-1:0] e_p0;
                #1;
                hp = ph % 6;
                if (kind == 0) begin
                    e_ale = hp < 2; e_psen = !(hp >= 3); e_rd = 1; e_wr = 1;
                    e_oe = hp < 3; e_p0 = a[DW-1:0];
                end else begin
                    e_ale = ph < 2; e_psen = 1;
                    e_rd = !(kind == 1 && ph >= 5 && ph <= 10);
                    e_wr = !(kind == 2 && ph >= 5 && ph <= 10);
                    e_oe = (ph < 3) || (kind == 2);
                    e_p0 = (ph < 3) ? a[DW-1:0] : wd;
                end
                chk(kind == 0 ? "R2 ale" : "R6 ale", 32'(ale), 32'(e_ale));
                chk(kind == 0 ? "R4 psen_n" : "R6 psen_n", 32'(psen_n), 32'(e_psen));
                chk("R7 rd_n", 32'(rd_n), 32'(e_rd));
                chk("R8 wr_n", 32'(wr_n), 32'(e_wr));
                chk(kind == 2 ? "R8 p0_oe" : "R3 p0_oe", 32'(p0_oe), 32'(e_oe));
                if (e_oe)
                    chk(kind == 2 ? "R8 p0_out" : "R3 p0_out", 32'(p0_out), 32'(e_p0));
                chk("R9 p2_out", 32'(p2_out), 32'(a[AW-1:DW]));
                chk("R10 half_last", 32'(half_last), 32'(hp == 5));
                chk("R10 mc_last", 32'(mc_last), 32'(ph == 11));
                chk("R11 one strobe", 32'((!psen_n + !rd_n + !wr_n) <= 1), 32'd1);
                chk("R5 rdata_valid", 32'(rdata_valid), 32'(pend_valid));
                if (pend_valid) chk("R5 rdata", 32'(rdata), 32'(pend_data));

                pin = DW'((m * 16 + ph) ^ 8'h5A);
                p0_in = pin;
                sample_now = (kind == 0 && hp == 5) || (kind == 1 && ph == 10);
                if (ph == 5 && kind == 0) begin
                    code_addr = fa(m, 1);
                    na = code_addr;
                end
                if (ph == 11) begin
                    nk = sched(m + 1);
                    code_addr  = fa(m + 1, 0);
                    data_addr  = da(m + 1);
                    data_wdata = wdv(m + 1);
                    data_rd    = (nk == 1) || (nk == 3);
                    data_wr    = (nk == 2) || (nk == 3);
                    if (nk == 0) na = fa(m + 1, 0);
                    else         na = da(m + 1);
                    if (nk == 2) nwd = wdv(m + 1);
                    else         nwd = wd;
                end
                @(negedge clk);
                pend_valid = sample_now;
                pend_data  = pin;
                if (ph == 5 && kind == 0) a = na;
                if (ph == 11) begin
                    kind = (nk == 3) ? 1 : nk;
                    a    = na;
                    wd   = nwd;
                end
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule